// File: doc/BRIEF.md
# Protection Region Address Decoder

This block serves a single entry of a physical memory protection table. From the entry's configuration byte, its own address register and the address register of the entry below it, the block works out an inclusive byte range, given as a start and an end address. It holds that range in registers and compares a query address against it on every cycle. The hit output marks a query that lies inside an active region. Choosing among entries by priority and checking permissions are left to the logic around it.

Address registers hold a byte address divided by four. A two-bit match-mode field, in bits [4:3] of the configuration byte, picks one of four encodings:

- 0: disabled.
- 1: top-of-range. The base comes from the lower neighbour.
- 2: a naturally aligned four-byte word.
- 3: a naturally aligned power-of-two region. Its size follows from the number of trailing ones in the address register.

A two-state controller governs when the range registers reload. Reset enters `ST_SETTLE`. From `ST_SETTLE` the controller moves to `ST_READY` on the next edge and loads the registers as it goes, unless `upd_i` is high, in which case it stays in `ST_SETTLE` and loads again. From `ST_READY`, a high `upd_i` returns it to `ST_SETTLE`. Without `upd_i` it stays in `ST_READY`. The environment pulses `upd_i` in the cycle where new register values appear on the inputs, and then holds those values.

Top module: `region_decoder`

## Requirements
- R1: While reset is active, valid_o, hit_o, start_o and end_o are all zero. The first decode is loaded at the first clock edge after reset is released, and valid_o is high after that edge.
- R2: After a one-cycle pulse on upd_i, valid_o is low for exactly the following cycle and hit_o is zero in that cycle. After the next edge the range reflects the new inputs and valid_o is high again.
- R3: With mode field 0 (disabled), start_o is 0 and end_o is all ones, and hit_o is never asserted.
- R4: With mode field 1 (top-of-range), start_o equals the previous address times 4 and end_o equals this address times 4 minus 1, modulo 2^PA_W. A zero address therefore gives an end of all ones.
- R5: In top-of-range mode, when the computed start exceeds the computed end, both start_o and end_o are zero.
- R6: With mode field 2, start_o equals the address times 4 and end_o equals start_o plus 3.
- R7: With mode field 3, k trailing ones in the address register give a region of 2^(k+3) bytes aligned to its size. With k = 0 the region is 8 bytes, with k = 1 it is 16 bytes, and so on.
- R8: With mode field 3 and an address whose low PA_W-3 bits are all ones, the region covers the whole space: start 0 and end all ones.
- R9: hit_o is high exactly when valid_o is high, the mode is not 0, and start_o <= query_i <= end_o. Both bounds are inclusive.
- R10: Configuration bits other than [4:3] have no effect on the decoded range.
- R11: With parameter IS_FIRST set, the previous-address input is ignored and treated as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Pulse: this entry or the previous address was rewritten |
| cfg_i | input | 8 | Entry configuration byte; mode in bits [4:3] |
| addr_i | input | PA_W-2 | This entry's address register (byte address / 4) |
| prev_addr_i | input | PA_W-2 | Previous entry's address register |
| query_i | input | PA_W | Byte address to test |
| start_o | output | PA_W | Registered inclusive start byte address |
| end_o | output | PA_W | Registered inclusive end byte address |
| valid_o | output | 1 | Range registers hold the current decode |
| hit_o | output | 1 | Query lies inside an active region |

## Verification
The bench targets the boundaries where an off-by-one error would slip through:

- **Top-of-range with equal or reversed neighbours.** A decoder that skips the clamp would report an inverted range.
- **A zero top address.** A decoder that saturates instead of wrapping would end the range at zero.
- **Power-of-two regions with 0, 1, 2 and 8 trailing ones, and the all-ones address.** A miscounted run would give a region half or double the expected size, or misaligned.
- **Queries one byte either side of each bound.** An exclusive compare would drop the end byte.

It also confirms that the settle cycle suppresses hits, that stray configuration bits are ignored, and that the first-entry variant ignores its neighbour.

// File: rtl/prd_pkg.sv
package prd_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_e;

    typedef enum logic {
        ST_SETTLE = 1'b0,
        ST_READY  = 1'b1
    } dec_state_e;

    localparam int MODE_LSB = 3;

    function automatic match_e mode_of(input logic [7:0] cfg);
        return match_e'(cfg[MODE_LSB+1:MODE_LSB]);
    endfunction

endpackage

// File: rtl/prd_napot_mask.sv
// Thermometer mask of the low bits covered by a power-of-two region.
// Bits [2:0] are always covered; bit j+3 is covered when the address
// register bits [j:0] are all ones.
module prd_napot_mask #(
    parameter int PA_W = 34,
    localparam int AW  = PA_W - 2
) (
    input  logic [AW-2:0]   addr_low_i,
    output logic [PA_W-1:0] mask_o
);

    logic [AW-2:0] run;

    assign run[0] = addr_low_i[0];

    for (genvar j = 1; j <= AW-2; j++) begin : g_run
        assign run[j] = run[j-1] & addr_low_i[j];
    end

    assign mask_o[2:0] = 3'b111;

    for (genvar j = 0; j <= AW-2; j++) begin : g_mask
        assign mask_o[j+3] = run[j];
    end

endmodule

// File: rtl/prd_range_calc.sv
// Combinational decode of the four range encodings.
module prd_range_calc
    import prd_pkg::*;
#(
    parameter int PA_W = 34,
    localparam int AW  = PA_W - 2
) (
    input  match_e          mode_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [AW-1:0]   prev_i,
    output logic [PA_W-1:0] lo_o,
    output logic [PA_W-1:0] hi_o
);

    logic [PA_W-1:0] base;
    logic [PA_W-1:0] tor_lo;
    logic [PA_W-1:0] tor_hi;
    logic [PA_W-1:0] pow_mask;

    assign base   = {addr_i, 2'b00};
    assign tor_lo = {prev_i, 2'b00};
    assign tor_hi = base - {{(PA_W-1){1'b0}}, 1'b1};

    prd_napot_mask #(.PA_W(PA_W)) u_mask (
        .addr_low_i (addr_i[AW-2:0]),
        .mask_o     (pow_mask)
    );

    always_comb begin
        unique case (mode_i)
            MATCH_OFF: begin
                lo_o = '0;
                hi_o = '1;
            end
            MATCH_TOR: begin
                if (tor_lo > tor_hi) begin
                    lo_o = '0;
                    hi_o = '0;
                end else begin
                    lo_o = tor_lo;
                    hi_o = tor_hi;
                end
            end
            MATCH_NA4: begin
                lo_o = base;
                hi_o = base + {{(PA_W-2){1'b0}}, 2'b11};
            end
            MATCH_NAPOT: begin
                lo_o = base & ~pow_mask;
                hi_o = base | pow_mask;
            end
            default: begin
                lo_o = '0;
                hi_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/prd_bound_cmp.sv
// Inclusive bound compare.
module prd_bound_cmp #(
    parameter int PA_W = 34
) (
    input  logic            en_i,
    input  logic [PA_W-1:0] lo_i,
    input  logic [PA_W-1:0] hi_i,
    input  logic [PA_W-1:0] q_i,
    output logic            hit_o
);

    assign hit_o = en_i && (q_i >= lo_i) && (q_i <= hi_i);

endmodule

// File: rtl/region_decoder.sv
module region_decoder
    import prd_pkg::*;
#(
    parameter int PA_W     = 34,
    parameter bit IS_FIRST = 1'b0,
    localparam int AW      = PA_W - 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            upd_i,
    input  logic [7:0]      cfg_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [AW-1:0]   prev_addr_i,
    input  logic [PA_W-1:0] query_i,
    output logic [PA_W-1:0] start_o,
    output logic [PA_W-1:0] end_o,
    output logic            valid_o,
    output logic            hit_o
);

    dec_state_e      state_q, state_d;
    match_e          mode_q;
    match_e          mode_in;
    logic [AW-1:0]   prev_eff;
    logic [PA_W-1:0] calc_lo, calc_hi;

    assign mode_in = mode_of(cfg_i);

    if (IS_FIRST) begin : g_first
        assign prev_eff = '0;
    end else begin : g_chain
        assign prev_eff = prev_addr_i;
    end

    prd_range_calc #(.PA_W(PA_W)) u_calc (
        .mode_i (mode_in),
        .addr_i (addr_i),
        .prev_i (prev_eff),
        .lo_o   (calc_lo),
        .hi_o   (calc_hi)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_SETTLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        unique case (state_q)
            ST_SETTLE: state_d = upd_i ? ST_SETTLE : ST_READY;
            ST_READY:  state_d = upd_i ? ST_SETTLE : ST_READY;
            default:   state_d = ST_SETTLE;
        endcase
    end

    // Range registers load on every edge spent in ST_SETTLE
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            start_o <= '0;
            end_o   <= '0;
            mode_q  <= MATCH_OFF;
        end else if (state_q == ST_SETTLE) begin
            start_o <= calc_lo;
            end_o   <= calc_hi;
            mode_q  <= mode_in;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_SETTLE: valid_o = 1'b0;
            ST_READY:  valid_o = 1'b1;
            default:   valid_o = 1'b0;
        endcase
    end

    prd_bound_cmp #(.PA_W(PA_W)) u_cmp (
        .en_i  (valid_o && (mode_q != MATCH_OFF)),
        .lo_i  (start_o),
        .hi_i  (end_o),
        .q_i   (query_i),
        .hit_o (hit_o)
    );

    // Checks
    logic [PA_W-1:0] pow_ref, pow_ref_nxt;
    assign pow_ref     = {addr_i, 2'b11};
    assign pow_ref_nxt = pow_ref + {{(PA_W-1){1'b0}}, 1'b1};

    a_r2_drop_after_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_i |=> !valid_o);

    a_r2_single_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!valid_o && !upd_i) |=> valid_o);

    a_r5_tor_ordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && mode_q == MATCH_TOR) |-> (start_o <= end_o));

    a_r9_hit_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> (valid_o && query_i >= start_o && query_i <= end_o));

    a_r3_off_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MATCH_OFF) |-> !hit_o);

    a_r7_pow_formula: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(state_q == ST_SETTLE) && mode_q == MATCH_NAPOT) |->
        (start_o == $past(pow_ref & pow_ref_nxt) && end_o == $past(pow_ref | pow_ref_nxt)));

endmodule

// File: tb/region_decoder_tb.sv
`timescale 1ns/1ps
module region_decoder_tb;

    localparam int PA_W = 34;
    localparam int AW   = PA_W - 2;
    localparam int NV   = 13;

    // {cfg, addr, prev, exp_start, exp_end}
    localparam logic [139:0] VEC [0:NV-1] = '{
        {8'h10, 32'h0000_0400, 32'h0, 34'h0_0000_1000, 34'h0_0000_1003}, // R6
        {8'h08, 32'h0000_0200, 32'h100, 34'h0_0000_0400, 34'h0_0000_07FF}, // R4
        {8'h08, 32'h0000_0200, 32'h300, 34'h0, 34'h0},                  // R5 reversed
        {8'h08, 32'h0000_0200, 32'h200, 34'h0, 34'h0},                  // R5 equal
        {8'h18, 32'h0000_1000, 32'h0, 34'h0_0000_4000, 34'h0_0000_4007}, // R7 k=0
        {8'h18, 32'h0000_1001, 32'h0, 34'h0_0000_4000, 34'h0_0000_400F}, // R7 k=1
        {8'h18, 32'h0000_1003, 32'h0, 34'h0_0000_4000, 34'h0_0000_401F}, // R7 k=2
        {8'h18, 32'h0000_00FF, 32'h0, 34'h0, 34'h0_0000_07FF},           // R7 k=8
        {8'h18, 32'hFFFF_FFFF, 32'h0, 34'h0, 34'h3_FFFF_FFFF},           // R8
        {8'h00, 32'h0000_1234, 32'h0, 34'h0, 34'h3_FFFF_FFFF},           // R3
        {8'hF7, 32'h0000_0010, 32'h5, 34'h0_0000_0040, 34'h0_0000_0043}, // R10
        {8'h08, 32'h0000_0000, 32'h0, 34'h0, 34'h3_FFFF_FFFF},           // R4 wrap
        {8'h10, 32'hFFFF_FFFF, 32'h0, 34'h3_FFFF_FFFC, 34'h3_FFFF_FFFF}  // R6 top
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            upd = 1'b0;
    logic [7:0]      cfg = 8'h10;
    logic [AW-1:0]   addr = 32'h400;
    logic [AW-1:0]   prev = '0;
    logic [PA_W-1:0] query = '0;
    logic [PA_W-1:0] s_o, e_o, s1_o, e1_o;
    logic            v_o, h_o, v1_o, h1_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    region_decoder #(.PA_W(PA_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .cfg_i(cfg),
        .addr_i(addr), .prev_addr_i(prev), .query_i(query),
        .start_o(s_o), .end_o(e_o), .valid_o(v_o), .hit_o(h_o)
    );

    region_decoder #(.PA_W(PA_W), .IS_FIRST(1'b1)) u_first (
        .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .cfg_i(cfg),
        .addr_i(addr), .prev_addr_i(prev), .query_i(query),
        .start_o(s1_o), .end_o(e1_o), .valid_o(v1_o), .hit_o(h1_o)
    );

    task automatic chk(input string tag, input logic [PA_W-1:0] act, input logic [PA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive new inputs with an update pulse; checks the settle cycle.
    task automatic apply(input logic [7:0] c, input logic [AW-1:0] a, input logic [AW-1:0] p);
        @(negedge clk);
        cfg  = c;
        addr = a;
        prev = p;
        upd  = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        chk("R2 valid low in settle cycle", {{(PA_W-1){1'b0}}, v_o}, '0);
        chk("R2 no hit in settle cycle", {{(PA_W-1){1'b0}}, h_o}, '0);
        @(negedge clk);
        chk("R2 valid back high", {{(PA_W-1){1'b0}}, v_o}, 1);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {{(PA_W-1){1'b0}}, v_o}, '0);
        chk("R1 hit in reset", {{(PA_W-1){1'b0}}, h_o}, '0);
        chk("R1 start in reset", s_o, '0);
        chk("R1 end in reset", e_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after first edge", {{(PA_W-1){1'b0}}, v_o}, 1);
        chk("R1 first decode start", s_o, 34'h1000);
        chk("R1 first decode end", e_o, 34'h1003);

        // Table walk (R3 R4 R5 R6 R7 R8 R10)
        for (int i = 0; i < NV; i++) begin
            logic [139:0] v;
            v = VEC[i];
            apply(v[139:132], v[131:100], v[99:68]);
            chk($sformatf("row %0d start (R3/R4/R5/R6/R7/R8/R10)", i), s_o, v[67:34]);
            chk($sformatf("row %0d end (R3/R4/R5/R6/R7/R8/R10)", i), e_o, v[33:0]);
        end

        // R9: inclusive bounds on a 16-byte region at 0x4000
        query = 34'h4000;
        apply(8'h18, 32'h1001, 32'h0);
        query = 34'h3FFF; #1;
        chk("R9 below start", {{(PA_W-1){1'b0}}, h_o}, '0);
        query = 34'h4000; #1;
        chk("R9 at start", {{(PA_W-1){1'b0}}, h_o}, 1);
        query = 34'h400F; #1;
        chk("R9 at end", {{(PA_W-1){1'b0}}, h_o}, 1);
        query = 34'h4010; #1;
        chk("R9 above end", {{(PA_W-1){1'b0}}, h_o}, '0);

        // R3: disabled mode never hits, even inside its nominal range
        apply(8'h00, 32'h1001, 32'h0);
        query = 34'h4000; #1;
        chk("R3 disabled no hit", {{(PA_W-1){1'b0}}, h_o}, '0);

        // R11: first-entry variant ignores prev
        apply(8'h08, 32'h200, 32'h100);
        chk("R11 first entry start", s1_o, '0);
        chk("R11 first entry end", e1_o, 34'h7FF);
        chk("R4 chained entry start", s_o, 34'h400);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule